// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits behind a byte-level serial slave front end in a serial EEPROM model. Once the front end has decoded a write command and its word address, it reports the start of the command with that address. It then hands over each received data byte with a one-cycle strobe. The controller collects these bytes in a page latch. It commits the latch to an on-chip byte array only when the front end reports a Stop condition.

The commit is a self-timed write cycle whose length is set in clock ticks by a parameter. During the cycle the controller raises a busy flag, which the front end uses to withhold acknowledges. While busy, the controller ignores all command, data and Stop strobes. The array has a synchronous read port so that surrounding logic can fetch stored bytes.

The array size is set by an address-width parameter. The default is small to keep elaboration light, and a width of 15 gives a 32K x 8 array. The page size defaults to 64 bytes.

Top module: `page_wbuf_ctrl`

## Requirements
- R1: A page is PAGE (64) bytes aligned to a multiple of PAGE. A commit writes only addresses whose upper bits equal the upper bits of the address given with the command start.
- R2: Each accepted data byte is stored at the offset held in the low six bits of `ptr_o`. Those six bits then increment modulo 64 and the upper bits stay unchanged. After a commit, `ptr_o` points to the location after the last byte received.
- R3: If more than 64 bytes arrive in one command, the offset wraps to the page start and the later bytes replace the earlier ones at the same offsets.
- R4: The array is not written before a committing Stop. `busy` rises in the first cycle after the clock edge that samples a `stop_evt` which commits.
- R5: `wp_lvl` is sampled only in the cycle of `stop_evt`. If it is high there, nothing is written, `busy` stays low, and a new command is accepted in the next cycle. Changes of `wp_lvl` while busy do not affect the running cycle.
- R6: After a committing Stop, `busy` stays high for exactly WR_TICKS cycles. When it falls, every received byte is readable from the array.
- R7: While `busy` is high, `cmd_start`, `byte_vld` and `stop_evt` have no effect on `ptr_o`, on the array contents or on the length of the cycle.
- R8: Within a committed page, bytes not received in the command keep their previous contents.
- R9: A `cmd_start` before the Stop discards the bytes buffered so far, and only the bytes of the new command are committed. A Stop with no data bytes since the command start starts no write cycle.
- R10: After reset, `busy` is 0 and `ptr_o` is 0. If strobes coincide, `stop_evt` takes priority over `cmd_start`, and `cmd_start` takes priority over `byte_vld`. A `byte_vld` outside a command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Pulse: a write command with address `cmd_addr` begins |
| cmd_addr | input | ADDR_W | Starting word address of the command |
| byte_vld | input | 1 | Pulse: `byte_data` holds a received data byte |
| byte_data | input | 8 | Received data byte |
| stop_evt | input | 1 | Pulse: Stop condition seen on the bus |
| wp_lvl | input | 1 | Write-protect level, high inhibits the commit |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data, one cycle after `rd_addr` |
| ptr_o | output | ADDR_W | Current address pointer |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The bench targets the offset wrap. A design that carries into the upper address bits would spill a 70-byte burst into the next page, where the page should keep only its last 64 bytes. Partial-page writes are read back in full: a controller that rewrites unreceived offsets with stale latch data would corrupt the neighbouring bytes. Write protect is raised at Stop, and also only during the cycle. Wrong sampling would either write protected data or cut a running cycle short. Strobes fired while busy, a restart before Stop, and an empty Stop check that the controller neither moves its pointer nor starts a spurious cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int DATA_W = 8;
  localparam int PAGE_BYTES = 64;
endpackage

// File: rtl/pwb_latch.sv
module pwb_latch #(
  parameter int PAGE = 64,
  parameter int DW   = 8,
  localparam int OW  = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [OW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [OW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [PAGE-1:0] mask
);
  logic [DW-1:0] mem [PAGE];
  logic [PAGE-1:0] mask_q;

  // Byte storage: no reset so that it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) mask_q <= '0;
    else if (wr_en) mask_q[wr_idx] <= 1'b1;
  end

  assign rd_data = mem[rd_idx];
  assign mask    = mask_q;

  p_wr_marks_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> mask_q[$past(wr_idx)]);
endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int AW = 10,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int TICKS = 80,
  localparam int TW = $clog2(TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [TW-1:0] tick
);
  logic          busy_q;
  logic [TW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      tick_q <= '0;
    end else if (busy_q) begin
      tick_q <= tick_q + 1'b1;
      if (tick_q == TW'(TICKS - 1)) busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      tick_q <= '0;
    end
  end

  assign busy = busy_q;
  assign tick = tick_q;

  p_cycle_len_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && tick_q != TW'(TICKS - 1)) |=> busy_q);
endmodule

// File: rtl/page_wbuf_ctrl.sv
module page_wbuf_ctrl #(
  parameter int ADDR_W   = 10,
  parameter int PAGE     = pwb_pkg::PAGE_BYTES,
  parameter int WR_TICKS = 80,           // must be >= PAGE
  localparam int DW = pwb_pkg::DATA_W,
  localparam int OW = $clog2(PAGE),
  localparam int TW = $clog2(WR_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_vld,
  input  logic [DW-1:0]     byte_data,
  input  logic              stop_evt,
  input  logic              wp_lvl,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              busy
);
  logic              coll_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [PAGE-1:0]   mask;
  logic [DW-1:0]     lat_q;
  logic [TW-1:0]     tick;
  logic              stop_hit, start_hit, byte_hit, commit;
  logic              arr_we;
  logic [OW-1:0]     sweep_idx;

  // Stop outranks start, start outranks data; all ignored while busy
  assign stop_hit  = !busy && stop_evt;
  assign start_hit = !busy && !stop_evt && cmd_start;
  assign byte_hit  = !busy && !stop_evt && !cmd_start && byte_vld && coll_q;
  assign commit    = stop_hit && coll_q && (|mask) && !wp_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      coll_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (stop_hit)       coll_q <= 1'b0;
      else if (start_hit) coll_q <= 1'b1;
      if (start_hit)      ptr_q <= cmd_addr;
      else if (byte_hit)  ptr_q <= {ptr_q[ADDR_W-1:OW], ptr_q[OW-1:0] + 1'b1};
    end
  end

  pwb_latch #(.PAGE(PAGE), .DW(DW)) u_latch (
    .clk(clk), .rst(rst), .clr(start_hit),
    .wr_en(byte_hit), .wr_idx(ptr_q[OW-1:0]), .wr_data(byte_data),
    .rd_idx(sweep_idx), .rd_data(lat_q), .mask(mask)
  );

  pwb_timer #(.TICKS(WR_TICKS)) u_timer (
    .clk(clk), .rst(rst), .start(commit), .busy(busy), .tick(tick)
  );

  // Sweep every page offset in the first PAGE ticks; write the received ones
  assign sweep_idx = tick[OW-1:0];
  assign arr_we    = busy && (int'(tick) < PAGE) && mask[sweep_idx];

  pwb_array #(.AW(ADDR_W), .DW(DW)) u_array (
    .clk(clk), .we(arr_we),
    .waddr({ptr_q[ADDR_W-1:OW], sweep_idx}), .wdata(lat_q),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign ptr_o = ptr_q;

  p_ptr_in_page_r2: assert property (@(posedge clk) disable iff (rst)
    byte_hit |=> (ptr_q[ADDR_W-1:OW] == $past(ptr_q[ADDR_W-1:OW])) &&
                 (ptr_q[OW-1:0] == OW'($past(ptr_q[OW-1:0]) + 1'b1)));
  p_busy_after_stop_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_evt));
  p_wp_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && stop_evt && wp_lvl) |=> !busy);
  p_busy_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ptr_q));
  p_empty_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && stop_evt && mask == '0) |=> !busy);
endmodule

// File: tb/page_wbuf_ctrl_bench.sv
module page_wbuf_ctrl_bench;
  localparam int AW = 10;
  localparam int PG = 64;
  localparam int WT = 80;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst = 1;
  logic cmd_start = 0, byte_vld = 0, stop_evt = 0, wp_lvl = 0;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0] byte_data = '0;
  logic [7:0] rd_data;
  logic [AW-1:0] ptr_o;
  logic busy;

  int tests = 0, fails = 0;
  bit finished = 0;

  page_wbuf_ctrl #(.ADDR_W(AW), .PAGE(PG), .WR_TICKS(WT)) u_page_wbuf_ctrl (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt),
    .wp_lvl(wp_lvl), .rd_addr(rd_addr), .rd_data(rd_data),
    .ptr_o(ptr_o), .busy(busy));

  always #10 clk = ~clk;

  // Behavioural reference model
  int  ref_mem [DEPTH];
  bit  known [DEPTH];
  int  pend [PG];
  bit  pend_v [PG];
  int  m_ptr, m_left, m_cnt;
  bit  m_busy, m_coll;

  always @(posedge clk) begin
    if (rst) begin
      m_ptr = 0; m_busy = 0; m_coll = 0; m_cnt = 0; m_left = 0;
    end else if (m_busy) begin
      m_left = m_left - 1;
      if (m_left == 0) m_busy = 0;
    end else if (stop_evt) begin
      if (m_coll && m_cnt > 0 && !wp_lvl) begin
        for (int k = 0; k < PG; k++)
          if (pend_v[k]) begin
            ref_mem[(m_ptr / PG) * PG + k] = pend[k];
            known[(m_ptr / PG) * PG + k] = 1;
          end
        m_busy = 1; m_left = WT;
      end
      m_coll = 0;
    end else if (cmd_start) begin
      m_coll = 1; m_ptr = int'(cmd_addr); m_cnt = 0;
      for (int k = 0; k < PG; k++) pend_v[k] = 0;
    end else if (byte_vld && m_coll) begin
      pend[m_ptr % PG] = int'(byte_data);
      pend_v[m_ptr % PG] = 1;
      m_ptr = (m_ptr / PG) * PG + ((m_ptr + 1) % PG);
      m_cnt++;
    end
  end

  // Compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      tests++;
      if (busy !== m_busy) begin
        fails++;
        $display("FAIL R6 busy act=%0b exp=%0b t=%0t", busy, m_busy, $time);
      end
      tests++;
      if (int'(ptr_o) != m_ptr) begin
        fails++;
        $display("FAIL R2 ptr act=%0h exp=%0h t=%0t", ptr_o, m_ptr, $time);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic start_cmd(input int a);
    @(negedge clk); cmd_start = 1; cmd_addr = AW'(a);
    @(negedge clk); cmd_start = 0;
  endtask

  task automatic put_byte(input int d);
    @(negedge clk); byte_vld = 1; byte_data = 8'(d);
    @(negedge clk); byte_vld = 0;
  endtask

  task automatic stop_cmd(input bit wp);
    @(negedge clk); stop_evt = 1; wp_lvl = wp;
    @(negedge clk); stop_evt = 0; wp_lvl = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic read_chk(input int a, input string tag);
    @(negedge clk); rd_addr = AW'(a);
    @(negedge clk);
    if (known[a]) chk(int'(rd_data) == ref_mem[a], tag, int'(rd_data), ref_mem[a]);
  endtask

  task automatic page_chk(input int base, input string tag);
    for (int k = 0; k < PG; k++) read_chk(base + k, tag);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int busy_cnt;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: reset state
    chk(busy == 0, "R10 busy after reset", busy, 0);
    chk(ptr_o == 0, "R10 ptr after reset", ptr_o, 0);
    // R10: data byte outside a command is ignored
    put_byte(8'h11);
    chk(ptr_o == 0, "R10 stray byte", ptr_o, 0);

    // R1 R6: byte write, busy length counted
    start_cmd(10'h045); put_byte(8'hA5);
    chk(ptr_o == 10'h046, "R2 ptr after byte", ptr_o, 10'h046);
    stop_cmd(0);
    busy_cnt = 0;
    while (busy) begin busy_cnt++; @(negedge clk); end
    chk(busy_cnt == WT, "R6 busy length", busy_cnt, WT);
    read_chk(10'h045, "R1 byte write data");
    chk(ptr_o == 10'h046, "R2 ptr after commit", ptr_o, 10'h046);

    // R2 R3: start near page end, wrap to page start
    start_cmd(10'h0FC);
    for (int i = 0; i < 10; i++) put_byte(8'h30 + i);
    chk(ptr_o == 10'h0C6, "R2 wrapped ptr", ptr_o, 10'h0C6);
    stop_cmd(0); wait_idle();
    page_chk(10'h0C0, "R3 wrap page");
    page_chk(10'h100, "R1 next page untouched");

    // R3: 70 bytes overwrite first six
    start_cmd(10'h100);
    for (int i = 0; i < 70; i++) put_byte(i * 3 + 1);
    stop_cmd(0); wait_idle();
    page_chk(10'h100, "R3 overwrite");
    chk(known[10'h140] == 0, "R1 no spill", 0, 0);

    // R8: partial write keeps other bytes; R4: nothing written before stop
    start_cmd(10'h110);
    for (int i = 0; i < 3; i++) put_byte(8'hE0 + i);
    read_chk(10'h110, "R4 before stop");
    stop_cmd(0); wait_idle();
    page_chk(10'h100, "R8 partial page");

    // R5: write protect at stop blocks the write, ready next cycle
    start_cmd(10'h100); put_byte(8'h5A);
    stop_cmd(1);
    chk(busy == 0, "R5 protected no busy", busy, 0);
    read_chk(10'h100, "R5 protected data");
    start_cmd(10'h101);
    chk(ptr_o == 10'h101, "R5 accepts next cmd", ptr_o, 10'h101);

    // R5: protect raised during busy has no effect; R7: strobes while busy
    put_byte(8'h77);
    stop_cmd(0);
    @(negedge clk); wp_lvl = 1;
    start_cmd(10'h2A0); put_byte(8'h99); stop_cmd(1);
    chk(ptr_o == 10'h102, "R7 ptr frozen", ptr_o, 10'h102);
    wp_lvl = 1;
    wait_idle();
    wp_lvl = 0;
    read_chk(10'h101, "R5 wp during busy");
    chk(known[10'h2A0] == 0, "R7 no write from busy strobes", 0, 0);
    page_chk(10'h100, "R7 page intact");

    // R9: restart discards buffered bytes; empty stop starts no cycle
    start_cmd(10'h200);
    put_byte(8'h01); put_byte(8'h02);
    start_cmd(10'h208);
    put_byte(8'hC3);
    stop_cmd(0); wait_idle();
    chk(known[10'h200] == 0, "R9 discarded bytes", 0, 0);
    read_chk(10'h208, "R9 new command data");
    start_cmd(10'h300); stop_cmd(0);
    chk(busy == 0, "R9 empty stop no busy", busy, 0);

    // R10: stop outranks start in the same cycle
    start_cmd(10'h310); put_byte(8'h42);
    @(negedge clk); stop_evt = 1; cmd_start = 1; cmd_addr = 10'h3F0;
    @(negedge clk); stop_evt = 0; cmd_start = 0;
    chk(ptr_o == 10'h311, "R10 stop priority", ptr_o, 10'h311);
    wait_idle();
    read_chk(10'h310, "R10 stop priority data");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule